// File: doc/BRIEF.md
# Card Clock Divider with Deferred Update

This block derives a card clock from a reference clock. A programmable divider sets the rate: an 8-bit value n above zero gives a card clock of the reference frequency over 2·n, and zero passes the reference clock straight through. A separate enable bit switches the card clock on or off. For logic that runs on the reference clock, the block also gives a one-cycle tick that marks each rising card-clock edge.

Software writes the divider and the enable into shadow registers, which do not touch the running clock. A write to the command register with both the start bit and the update-only bit set requests a commit. The start bit then reads back as 1 until the shadow values have been copied into the active divider, and then it clears itself. The commit happens only while the card clock is low, so the clock never produces a short pulse. If the command also sets the wait-for-data bit, the commit is further held off while the data-busy input is high. A command write that arrives while a commit is still pending is dropped and raises a sticky lock error, which software clears by writing 1 to it.

Top module: `cardclk_div`

## Requirements
- R1: After reset the card clock and the tick are low, no commit is pending, the lock error is clear, and every register reads 0. Register selects: 0 = divider (bits 7:0), 1 = enable (bit 0), 2 = command, 3 = status.
- R2: Writes to the divider or enable registers change only the shadow values. The card clock and the tick keep their current behaviour until a commit.
- R3: A command write with bit 31 (start) and bit 21 (update-only) both set, while nothing is pending, makes a commit pending. Bit 31 of the command register reads 1 in the cycle after the write and returns to 0 once the shadow values are active.
- R4: A pending commit is applied only at a clock edge where the card clock is low. The new phase then begins with a low half-period.
- R5: When the accepted command had bit 13 (wait for data) set, the commit is held off for as long as data_busy_i is high.
- R6: With enable 1 and divider n > 0, the card clock is high for n reference cycles and low for n reference cycles. The tick is high for exactly one reference cycle per card period, in the cycle just before the card clock rises.
- R7: With enable 1 and divider 0, the card clock follows the reference clock, and the tick is high in every cycle.
- R8: With enable 0 the card clock stays low and the tick is never asserted.
- R9: A command write while a commit is pending sets the lock error (lock_err_o, and status bit 12) and is otherwise ignored: the pending commit keeps its original wait-for-data setting.
- R10: Writing the status register with bit 12 set clears the lock error. Writing it with bit 12 clear leaves the lock error unchanged.
- R11: A command write that lacks the start bit or the update-only bit does not make a commit pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for the write |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 2 | Register select for the read |
| rd_data_o | output | 32 | Read data, combinational from rd_sel_i |
| data_busy_i | input | 1 | Data transfer in progress |
| card_clk_o | output | 1 | Generated card clock |
| card_clk_en_o | output | 1 | One-cycle tick before each rising card-clock edge |
| lock_err_o | output | 1 | Sticky lock error flag |

## Verification
A write is taken at the edge where wr_en_i is high. The start bit therefore reads 1 just after that edge, and the earliest commit is at the following edge, provided the card clock is low there and the busy condition is met. After a commit, the divided clock is low for n edges and rises at the n-th edge. The tick rises with the edge just before that. When the divider is 0, the bypass select changes at the next falling reference edge, so the card clock follows the reference clock one cycle after the commit. The bench model advances once per rising edge with exactly this latency. It compares the clock, the tick and the lock flag 5 ns after every edge, and it reads the registers half a cycle after an edge, when the state is stable.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;
   typedef enum logic [1:0] {
      SEL_DIV = 2'd0,
      SEL_ENA = 2'd1,
      SEL_CMD = 2'd2,
      SEL_STS = 2'd3
   } reg_sel_e;

   localparam int START_BIT   = 31;
   localparam int UPDATE_BIT  = 21;
   localparam int WAITDAT_BIT = 13;
   localparam int LOCKERR_BIT = 12;
endpackage

// File: rtl/cardclk_regs.sv
module cardclk_regs
   import cardclk_pkg::*;
#(
   parameter int DIV_W  = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_sel_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [1:0]        rd_sel_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              data_busy_i,
   input  logic              safe_i,
   output logic [DIV_W-1:0]  shd_div_o,
   output logic              shd_en_o,
   output logic              commit_o,
   output logic              pend_o,
   output logic              lock_o
);
   logic [DIV_W-1:0] div_q;
   logic             ena_q;
   logic             pend_q, wait_q, upd_q, lock_q;
   logic             cmd_wr, start_ok, lock_set, lock_clr;

   assign cmd_wr   = wr_en_i && (wr_sel_i == SEL_CMD);
   assign start_ok = cmd_wr && !pend_q && wr_data_i[START_BIT] && wr_data_i[UPDATE_BIT];
   assign commit_o = pend_q && (!wait_q || !data_busy_i) && safe_i;
   assign lock_set = cmd_wr && pend_q;
   assign lock_clr = wr_en_i && (wr_sel_i == SEL_STS) && wr_data_i[LOCKERR_BIT];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_q  <= '0;
         ena_q  <= 1'b0;
         pend_q <= 1'b0;
         wait_q <= 1'b0;
         upd_q  <= 1'b0;
         lock_q <= 1'b0;
      end else begin
         if (wr_en_i && (wr_sel_i == SEL_DIV)) div_q <= wr_data_i[DIV_W-1:0];
         if (wr_en_i && (wr_sel_i == SEL_ENA)) ena_q <= wr_data_i[0];
         if (start_ok) begin
            pend_q <= 1'b1;
            wait_q <= wr_data_i[WAITDAT_BIT];
            upd_q  <= 1'b1;
         end else if (commit_o) begin
            pend_q <= 1'b0;
         end
         if (lock_set)      lock_q <= 1'b1;
         else if (lock_clr) lock_q <= 1'b0;
      end
   end

   always_comb begin
      rd_data_o = '0;
      unique case (rd_sel_i)
         SEL_DIV: rd_data_o[DIV_W-1:0] = div_q;
         SEL_ENA: rd_data_o[0] = ena_q;
         SEL_CMD: begin
            rd_data_o[START_BIT]   = pend_q;
            rd_data_o[UPDATE_BIT]  = upd_q;
            rd_data_o[WAITDAT_BIT] = wait_q;
         end
         default: rd_data_o[LOCKERR_BIT] = lock_q;
      endcase
   end

   assign shd_div_o = div_q;
   assign shd_en_o  = ena_q;
   assign pend_o    = pend_q;
   assign lock_o    = lock_q;
endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen #(
   parameter int DIV_W       = 8,
   parameter bit ZERO_BYPASS = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             commit_i,
   input  logic [DIV_W-1:0] new_div_i,
   input  logic             new_en_i,
   output logic             card_clk_o,
   output logic             tick_o,
   output logic             low_o
);
   logic [DIV_W-1:0] act_div_q, cnt_q, div_eff;
   logic             act_en_q, ck_q, byp_q, byp_want, running, last;

   generate
      if (ZERO_BYPASS) begin : g_bypass
         assign byp_want = act_en_q && (act_div_q == '0);
         assign div_eff  = act_div_q;
      end else begin : g_no_bypass
         assign byp_want = 1'b0;
         assign div_eff  = (act_div_q == '0) ? DIV_W'(1) : act_div_q;
      end
   endgenerate

   assign running = act_en_q && !byp_want;
   assign last    = (cnt_q == (div_eff - DIV_W'(1)));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_div_q <= '0;
         act_en_q  <= 1'b0;
         cnt_q     <= '0;
         ck_q      <= 1'b0;
      end else if (commit_i) begin
         act_div_q <= new_div_i;
         act_en_q  <= new_en_i;
         cnt_q     <= '0;
         ck_q      <= 1'b0;
      end else if (running) begin
         if (last) begin
            cnt_q <= '0;
            ck_q  <= ~ck_q;
         end else begin
            cnt_q <= cnt_q + DIV_W'(1);
         end
      end else begin
         cnt_q <= '0;
         ck_q  <= 1'b0;
      end
   end

   // Bypass select moves on the falling edge, when both mux inputs are low.
   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byp_q <= 1'b0;
      else         byp_q <= byp_want;
   end

   assign card_clk_o = byp_q ? clk_i : ck_q;
   assign tick_o     = byp_want || (running && last && !ck_q);
   assign low_o      = !ck_q;
endmodule

// File: rtl/cardclk_div.sv
module cardclk_div #(
   parameter int DIV_W       = 8,
   parameter int DATA_W      = 32,
   parameter bit ZERO_BYPASS = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_sel_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [1:0]        rd_sel_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              data_busy_i,
   output logic              card_clk_o,
   output logic              card_clk_en_o,
   output logic              lock_err_o
);
   initial begin
      assert (DIV_W >= 1 && DIV_W <= 16) else $error("DIV_W out of range");
      assert (DATA_W >= 32) else $error("DATA_W must hold bit 31");
   end

   logic [DIV_W-1:0] shd_div;
   logic             shd_en, commit, pend, low;

   cardclk_regs #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_en_i     (wr_en_i),
      .wr_sel_i    (wr_sel_i),
      .wr_data_i   (wr_data_i),
      .rd_sel_i    (rd_sel_i),
      .rd_data_o   (rd_data_o),
      .data_busy_i (data_busy_i),
      .safe_i      (low),
      .shd_div_o   (shd_div),
      .shd_en_o    (shd_en),
      .commit_o    (commit),
      .pend_o      (pend),
      .lock_o      (lock_err_o)
   );

   cardclk_gen #(.DIV_W(DIV_W), .ZERO_BYPASS(ZERO_BYPASS)) u_gen (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .commit_i   (commit),
      .new_div_i  (shd_div),
      .new_en_i   (shd_en),
      .card_clk_o (card_clk_o),
      .tick_o     (card_clk_en_o),
      .low_o      (low)
   );
endmodule

// File: rtl/cardclk_div_chk.sv
module cardclk_div_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              wr_en_i,
   input logic [1:0]        wr_sel_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic              data_busy_i,
   input logic              card_clk_en_o,
   input logic              lock_err_o,
   input logic              pend,
   input logic              wait_f,
   input logic              ck_low,
   input logic              act_en
);
   assert_start_from_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend) |-> $past(wr_en_i && wr_sel_i == 2'd2));

   assert_commit_on_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pend) |-> $past(ck_low));

   assert_busy_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend && wait_f && data_busy_i) |=> pend);

   assert_off_no_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !act_en |-> !card_clk_en_o);

   assert_lock_on_conflict_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_sel_i == 2'd2 && pend) |=> lock_err_o);

   assert_lock_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_sel_i == 2'd3 && wr_data_i[12]) |=> !lock_err_o);
endmodule

bind cardclk_div cardclk_div_chk #(.DATA_W(DATA_W)) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .wr_en_i       (wr_en_i),
   .wr_sel_i      (wr_sel_i),
   .wr_data_i     (wr_data_i),
   .data_busy_i   (data_busy_i),
   .card_clk_en_o (card_clk_en_o),
   .lock_err_o    (lock_err_o),
   .pend          (pend),
   .wait_f        (u_regs.wait_q),
   .ck_low        (low),
   .act_en        (u_gen.act_en_q)
);

// File: tb/cardclk_div_tb_top.sv
module cardclk_div_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_sel = 2'd0;
   logic [31:0] rd_data;
   logic        busy = 1'b0;
   logic        card_clk, tick, lock_err;

   int tests = 0;
   int fails = 0;
   int pulses = 0;
   bit chk_on = 1'b0;

   always #10 clk = ~clk;

   cardclk_div dut_i (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
      .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
      .data_busy_i(busy), .card_clk_o(card_clk), .card_clk_en_o(tick),
      .lock_err_o(lock_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Behavioural reference: phase counter over a full card period.
   int m_div = 0, s_div = 0, ph = 0;
   bit m_en = 0, s_en = 0, m_pend = 0, m_wait = 0, m_lock = 0, m_lvl = 0, byp_prev = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_div = 0; s_div = 0; ph = 0; m_en = 0; s_en = 0;
         m_pend = 0; m_wait = 0; m_lock = 0; m_lvl = 0; byp_prev = 0;
      end else begin
         bit commit, cmdw;
         byp_prev = m_en && (m_div == 0);
         commit = m_pend && (!m_wait || !busy) && !m_lvl;
         cmdw = wr_en && (wr_sel == 2'd2);
         if (cmdw && m_pend) m_lock = 1;
         else if (wr_en && wr_sel == 2'd3 && wr_data[12]) m_lock = 0;
         if (cmdw && !m_pend && wr_data[31] && wr_data[21]) begin
            m_pend = 1; m_wait = wr_data[13];
         end else if (commit) m_pend = 0;
         if (commit) begin
            m_div = s_div; m_en = s_en; ph = 0;
         end else if (m_en && m_div != 0) ph = (ph + 1) % (2 * m_div);
         else ph = 0;
         m_lvl = m_en && (m_div != 0) && (ph >= m_div);
         if (wr_en && wr_sel == 2'd0) s_div = int'(wr_data[7:0]);
         if (wr_en && wr_sel == 2'd1) s_en = wr_data[0];
      end
      #5;
      if (rst_n && chk_on) begin
         chk("R6 card clock level", 32'(card_clk), 32'(byp_prev ? 1'b1 : m_lvl));
         chk("R6 tick", 32'(tick), 32'(m_en && (m_div == 0 || ph == m_div - 1)));
         chk("R9 lock flag", 32'(lock_err), 32'(m_lock));
         if (tick) pulses++;
      end
   end

   task automatic wr(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [31:0] v);
      @(negedge clk);
      rd_sel = s;
      #1 v = rd_data;
   endtask

   task automatic count_pulses(input int cycles, output int n);
      @(negedge clk);
      pulses = 0;
      repeat (cycles) @(negedge clk);
      n = pulses;
   endtask

   localparam logic [31:0] CMD_UPD  = 32'h8020_0000;
   localparam logic [31:0] CMD_WAIT = 32'h8020_2000;

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk_on = 1'b1;
      // R1 reset state
      for (int i = 0; i < 4; i++) begin
         rd(2'(i), v);
         chk("R1 register reset", v, 32'h0);
      end
      chk("R1 card clock low", 32'(card_clk), 32'h0);
      chk("R1 tick low", 32'(tick), 32'h0);
      chk("R1 lock clear", 32'(lock_err), 32'h0);
      // R2 shadow only
      wr(2'd0, 32'd3);
      wr(2'd1, 32'd1);
      count_pulses(10, n);
      chk("R2 no tick before commit", n, 0);
      chk("R2 card clock idle", 32'(card_clk), 32'h0);
      // R3 start bit handshake
      wr(2'd2, CMD_UPD);
      rd(2'd2, v);
      chk("R3 start pending", 32'(v[31]), 32'h1);
      repeat (3) @(posedge clk);
      rd(2'd2, v);
      chk("R3 start self-clears", 32'(v[31]), 32'h0);
      // R6 divide by 2*3
      count_pulses(60, n);
      chk("R6 ticks in 60 cycles div3", n, 10);
      // R11 incomplete commands
      wr(2'd2, 32'h8000_0000);
      rd(2'd2, v);
      chk("R11 start without update-only", 32'(v[31]), 32'h0);
      wr(2'd2, 32'h0020_0000);
      rd(2'd2, v);
      chk("R11 update-only without start", 32'(v[31]), 32'h0);
      // R5 wait for data
      wr(2'd0, 32'd1);
      busy = 1'b1;
      wr(2'd2, CMD_WAIT);
      repeat (10) @(posedge clk);
      rd(2'd2, v);
      chk("R5 held while busy", 32'(v[31]), 32'h1);
      busy = 1'b0;
      repeat (8) @(posedge clk);
      rd(2'd2, v);
      chk("R5 commit after busy drops", 32'(v[31]), 32'h0);
      count_pulses(20, n);
      chk("R6 ticks in 20 cycles div1", n, 10);
      // R9 conflicting command
      busy = 1'b1;
      wr(2'd2, CMD_WAIT);
      wr(2'd2, CMD_UPD);
      chk("R9 lock raised", 32'(lock_err), 32'h1);
      repeat (4) @(posedge clk);
      rd(2'd2, v);
      chk("R9 second write ignored", 32'(v[31]), 32'h1);
      rd(2'd3, v);
      chk("R9 status bit 12", v, 32'h0000_1000);
      // R10 write-one-to-clear
      wr(2'd3, 32'h0);
      chk("R10 zero write keeps lock", 32'(lock_err), 32'h1);
      wr(2'd3, 32'h0000_1000);
      chk("R10 one write clears lock", 32'(lock_err), 32'h0);
      busy = 1'b0;
      repeat (4) @(posedge clk);
      // R7 bypass
      wr(2'd0, 32'd0);
      wr(2'd2, CMD_UPD);
      repeat (4) @(posedge clk);
      count_pulses(10, n);
      chk("R7 tick every cycle", n, 10);
      @(posedge clk); #5;
      chk("R7 follows clock high", 32'(card_clk), 32'h1);
      @(negedge clk); #5;
      chk("R7 follows clock low", 32'(card_clk), 32'h0);
      // R4 commit waits for low phase
      wr(2'd0, 32'd4);
      wr(2'd2, CMD_UPD);
      repeat (4) @(posedge clk);
      do begin
         @(posedge clk);
         #6;
      end while (!tick);
      wr(2'd2, CMD_UPD);
      @(posedge clk);
      @(posedge clk);
      rd(2'd2, v);
      chk("R4 held during high phase", 32'(v[31]), 32'h1);
      repeat (6) @(posedge clk);
      rd(2'd2, v);
      chk("R4 applied in low phase", 32'(v[31]), 32'h0);
      // R8 disabled
      wr(2'd1, 32'd0);
      wr(2'd2, CMD_UPD);
      repeat (10) @(posedge clk);
      count_pulses(20, n);
      chk("R8 no tick when off", n, 0);
      chk("R8 clock low when off", 32'(card_clk), 32'h0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule